// File: doc/BRIEF.md
# Microstep Position Translator

This block converts step pulses into an electrical position for a two-phase bipolar stepper motor. It keeps a 64-position electrical angle index, where one index unit is 5.625 degrees. From that index it derives a signed current setpoint for each winding: phase 1 follows the cosine of the angle and phase 2 follows the sine. Both setpoints come from a 17-entry quarter-wave table that is folded across the four quadrants.

On every accepted step, the block also chooses a current-decay request for each winding. A winding whose current magnitude falls uses the decay style selected from outside. A winding whose magnitude rises or stays the same uses slow decay.

The step input is asynchronous and goes through a synchronizer before it is used. Resolution and direction are sampled only at the moment a step is accepted. Reset, a low logic supply and sleep all return the position to the 45 degree home point. A home indication is provided for a diagnostics neighbour. The current DACs, the comparators and the bridge drivers are outside this block.

Top module: `microstep_translator`

## Requirements
- R1: The resolution code `res_sel` = {MS2, MS1} sets the index increment per step: 2'b00 full step = 16, 2'b01 half step = 8, 2'b10 eighth step = 2, 2'b11 sixteenth step = 1.
- R2: A low-to-high transition on `step_in` moves the index by exactly one increment. The setpoints change after the third rising clock edge that follows the transition, counting the edge that first samples it. Keeping `step_in` high causes no further movement.
- R3: A change on `res_sel` or `dir_in` has no effect on any output until the next accepted step edge. The step edge uses the values present at that edge.
- R4: `dir_in` = 1 raises the index and `dir_in` = 0 lowers it. The index wraps modulo 64, so 48 + 16 gives 0 and 0 - 16 gives 48.
- R5: The index goes to home (index 8, 45 degrees, both setpoints +90) in three cases: when `rst_n` is low, while `sleep_n` is low, and while `vdd_low` is high. Step edges are ignored in all three cases.
- R6: `ph1_set` = round(127*cos(idx*5.625 deg)) and `ph2_set` = round(127*sin(idx*5.625 deg)), as signed 8-bit two's complement values, where 127 means 100% of full scale.
- R7: On a step, a phase whose new magnitude is below its previous magnitude takes the external decay setting. `decay_sel` maps 00 to slow, 01 to mixed, 10 to fast and 11 to mixed. A phase whose new magnitude is equal or higher takes slow. Output codes: slow = 2'b00, mixed = 2'b01, fast = 2'b10.
- R8: After reset, sleep or undervoltage, both decay outputs are mixed (2'b01). They keep their value between accepted steps.
- R9: `at_home` is high exactly while the index equals 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| sleep_n | input | 1 | Low while asleep; position held at home |
| vdd_low | input | 1 | High while the logic supply is under voltage |
| step_in | input | 1 | Asynchronous step request, rising edge active |
| dir_in | input | 1 | Direction: 1 raises the angle, 0 lowers it |
| res_sel | input | 2 | Resolution code {MS2, MS1} |
| decay_sel | input | 2 | Digitised external decay setting |
| ph1_set | output | 8 | Signed phase 1 (cosine) current setpoint |
| ph2_set | output | 8 | Signed phase 2 (sine) current setpoint |
| ph1_decay | output | 2 | Phase 1 decay request |
| ph2_decay | output | 2 | Phase 2 decay request |
| at_home | output | 1 | Index equals the home position |

## Verification
A corrupted index shows up on both setpoints in the same cycle. It also shifts every later step, because each move is relative to the stored position. The bench therefore compares both setpoints against a reference angle model after every step. A wrong increment, a wrong wrap or a wrong direction gives a setpoint mismatch at the first step that uses it, three clocks after the edge. Decay state is held between steps, so a bad magnitude comparison or a bad mode mapping is visible on the decay outputs from the step where it happens until the next step.

// File: rtl/microstep_pkg.sv
// Package: shared constants, decay encoding and the quarter-wave table.
// Assumes a 64-position electrical cycle; the table below matches that size.
package microstep_pkg;

    localparam int IDX_W    = 6;
    localparam int SET_W    = 8;
    localparam int N_POS    = 2 ** IDX_W;
    localparam int QUARTER  = N_POS / 4;
    localparam int HOME_IDX = QUARTER / 2;
    localparam int QTR_W    = IDX_W - 1;   // holds 0..QUARTER
    localparam int MAG_W    = SET_W - 1;
    localparam int N_PHASE  = 2;

    localparam int INC_FULL      = QUARTER;
    localparam int INC_HALF      = QUARTER / 2;
    localparam int INC_EIGHTH    = QUARTER / 8;
    localparam int INC_SIXTEENTH = QUARTER / 16;

    typedef enum logic [1:0] {
        DEC_SLOW  = 2'b00,
        DEC_MIXED = 2'b01,
        DEC_FAST  = 2'b10
    } decay_e;

    // Step increment for a resolution code {MS2, MS1}.
    function automatic logic [IDX_W-1:0] step_increment(input logic [1:0] code);
        case (code)
            2'b00:   return IDX_W'(INC_FULL);
            2'b01:   return IDX_W'(INC_HALF);
            2'b10:   return IDX_W'(INC_EIGHTH);
            default: return IDX_W'(INC_SIXTEENTH);
        endcase
    endfunction

    // Map the digitised external decay setting to a decay request.
    function automatic decay_e map_external(input logic [1:0] code);
        case (code)
            2'b00:   return DEC_SLOW;
            2'b10:   return DEC_FAST;
            default: return DEC_MIXED;
        endcase
    endfunction

    // First-quadrant sine magnitude, 127 = full scale, k in 0..16.
    function automatic logic [MAG_W-1:0] quarter_sine(input logic [QTR_W-1:0] k);
        case (k)
            5'd0:    return 7'd0;
            5'd1:    return 7'd12;
            5'd2:    return 7'd25;
            5'd3:    return 7'd37;
            5'd4:    return 7'd49;
            5'd5:    return 7'd60;
            5'd6:    return 7'd71;
            5'd7:    return 7'd81;
            5'd8:    return 7'd90;
            5'd9:    return 7'd98;
            5'd10:   return 7'd106;
            5'd11:   return 7'd112;
            5'd12:   return 7'd117;
            5'd13:   return 7'd122;
            5'd14:   return 7'd125;
            5'd15:   return 7'd126;
            default: return 7'd127;
        endcase
    endfunction

endpackage

// File: rtl/step_edge_sync.sv
// Synchronises the asynchronous step input and emits a one-cycle pulse
// on each rising edge. Assumes step high and low times span several clocks.
module step_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_async,
    output logic step_pulse
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // Shift the raw input through the synchroniser flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], step_async};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    assign step_pulse = chain[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/position_sequencer.sv
// Holds the electrical index. It samples resolution and direction only
// on an accepted step and returns to home on reset or hold.
// Assumes res_sel and dir_in are stable around the step edge.
module position_sequencer
    import microstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step_pulse,
    input  logic             dir_in,
    input  logic [1:0]       res_sel,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_next,
    output logic             advance
);
    logic [IDX_W-1:0] inc;

    // Work out the candidate next index from the live select inputs.
    always_comb begin
        inc      = step_increment(res_sel);
        idx_next = dir_in ? (idx + inc) : (idx - inc);
    end

    assign advance = step_pulse & ~hold;

    // Update the index: reset and hold go home, an accepted step moves.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= IDX_W'(HOME_IDX);
        else if (hold)    idx <= IDX_W'(HOME_IDX);
        else if (advance) idx <= idx_next;
    end

endmodule

// File: rtl/quarter_sine_lut.sv
// Signed setpoint for an index. A quarter-wave table is folded across
// the four quadrants. PHASE_SHIFT = QUARTER gives the cosine.
module quarter_sine_lut
    import microstep_pkg::*;
#(
    parameter int PHASE_SHIFT = 0
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [SET_W-1:0] setpoint,
    output logic [MAG_W-1:0]        magnitude
);
    logic [IDX_W-1:0] angle;
    logic [1:0]       quadrant;
    logic [QTR_W-1:0] offset;
    logic [QTR_W-1:0] k;

    // Fold the shifted angle into a first-quadrant table address and a sign.
    always_comb begin
        angle     = idx + IDX_W'(PHASE_SHIFT);
        quadrant  = angle[IDX_W-1:IDX_W-2];
        offset    = {1'b0, angle[IDX_W-3:0]};
        k         = quadrant[0] ? (QTR_W'(QUARTER) - offset) : offset;
        magnitude = quarter_sine(k);
        setpoint  = quadrant[1] ? -$signed({1'b0, magnitude})
                                :  $signed({1'b0, magnitude});
    end

endmodule

// File: rtl/decay_selector.sv
// Per-phase decay request. On a step, a falling magnitude takes the
// external setting and anything else takes slow. It resets to mixed.
module decay_selector
    import microstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             advance,
    input  logic [MAG_W-1:0] mag_now,
    input  logic [MAG_W-1:0] mag_next,
    input  logic [1:0]       ext_sel,
    output decay_e           mode
);
    decay_e mode_on_step;

    // Choose the request that a step would apply.
    always_comb begin
        if (mag_next < mag_now) mode_on_step = map_external(ext_sel);
        else                    mode_on_step = DEC_SLOW;
    end

    // Register the request; reset and hold restore mixed.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= DEC_MIXED;
        else if (hold)    mode <= DEC_MIXED;
        else if (advance) mode <= mode_on_step;
    end

endmodule

// File: rtl/microstep_translator.sv
// Top: step synchroniser, position sequencer, and for each phase the
// table lookups and a decay selector. sleep_n and vdd_low are assumed
// synchronous to clk.
module microstep_translator
    import microstep_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_n,
    input  logic                    vdd_low,
    input  logic                    step_in,
    input  logic                    dir_in,
    input  logic [1:0]              res_sel,
    input  logic [1:0]              decay_sel,
    output logic signed [SET_W-1:0] ph1_set,
    output logic signed [SET_W-1:0] ph2_set,
    output logic [1:0]              ph1_decay,
    output logic [1:0]              ph2_decay,
    output logic                    at_home
);
    logic             step_pulse;
    logic             hold;
    logic             advance;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_next;

    logic signed [SET_W-1:0] set_now  [N_PHASE];
    logic signed [SET_W-1:0] set_nxt  [N_PHASE];
    logic [MAG_W-1:0]        mag_now  [N_PHASE];
    logic [MAG_W-1:0]        mag_nxt  [N_PHASE];
    decay_e                  mode     [N_PHASE];

    assign hold = ~sleep_n | vdd_low;

    step_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_async (step_in),
        .step_pulse (step_pulse)
    );

    position_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .step_pulse (step_pulse),
        .dir_in     (dir_in),
        .res_sel    (res_sel),
        .idx        (idx),
        .idx_next   (idx_next),
        .advance    (advance)
    );

    // Phase 0 is the cosine winding, phase 1 the sine winding.
    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        localparam int SHIFT = (g == 0) ? QUARTER : 0;

        quarter_sine_lut #(.PHASE_SHIFT(SHIFT)) u_lut_now (
            .idx       (idx),
            .setpoint  (set_now[g]),
            .magnitude (mag_now[g])
        );

        quarter_sine_lut #(.PHASE_SHIFT(SHIFT)) u_lut_nxt (
            .idx       (idx_next),
            .setpoint  (set_nxt[g]),
            .magnitude (mag_nxt[g])
        );

        decay_selector u_decay (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (hold),
            .advance  (advance),
            .mag_now  (mag_now[g]),
            .mag_next (mag_nxt[g]),
            .ext_sel  (decay_sel),
            .mode     (mode[g])
        );
    end

    assign ph1_set   = set_now[0];
    assign ph2_set   = set_now[1];
    assign ph1_decay = mode[0];
    assign ph2_decay = mode[1];
    assign at_home   = (idx == IDX_W'(HOME_IDX));

endmodule

// File: rtl/microstep_translator_checks.sv
// Assertion checker, bound to the top module.
module microstep_translator_checks (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              vdd_low,
    input logic              step_pulse,
    input logic signed [7:0] ph1_set,
    input logic signed [7:0] ph2_set,
    input logic [1:0]        ph1_decay,
    input logic [1:0]        ph2_decay,
    input logic              at_home
);
    logic       held;
    logic [7:0] m1, m2;
    assign held = ~sleep_n | vdd_low;
    assign m1   = (ph1_set < 0) ? 8'(-ph1_set) : 8'(ph1_set);
    assign m2   = (ph2_set < 0) ? 8'(-ph2_set) : 8'(ph2_set);

    a_r5_hold_goes_home: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (at_home && ph1_set == 8'sd90 && ph2_set == 8'sd90));

    a_r8_hold_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (ph1_decay == 2'b01 && ph2_decay == 2'b01));

    a_r2_quiet_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_pulse && !held) |=> ($stable(ph1_set) && $stable(ph2_set)
                                    && $stable(ph1_decay) && $stable(ph2_decay)));

    a_r9_home_values: assert property (@(posedge clk) disable iff (!rst_n)
        at_home |-> (ph1_set == 8'sd90 && ph2_set == 8'sd90));

    a_r7_rise_is_slow: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(ph1_set) && !$past(held) && m1 >= $past(m1)) |-> ph1_decay == 2'b00);

    a_r7_rise_is_slow_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(ph2_set) && !$past(held) && m2 >= $past(m2)) |-> ph2_decay == 2'b00);

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_decay != 2'b11 && ph2_decay != 2'b11));

endmodule

bind microstep_translator microstep_translator_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_n    (sleep_n),
    .vdd_low    (vdd_low),
    .step_pulse (step_pulse),
    .ph1_set    (ph1_set),
    .ph2_set    (ph2_set),
    .ph1_decay  (ph1_decay),
    .ph2_decay  (ph2_decay),
    .at_home    (at_home)
);

// File: tb/microstep_translator_bench.sv
// Directed bench with an independent angle model.
module microstep_translator_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0, sleep_n = 1'b1, vdd_low = 1'b0;
    logic step_in = 1'b0, dir_in = 1'b1;
    logic [1:0] res_sel = 2'b11, decay_sel = 2'b00;
    logic signed [7:0] ph1_set, ph2_set;
    logic [1:0] ph1_decay, ph2_decay;
    logic at_home;

    int tests = 0, fails = 0;
    bit done = 0;
    int m_idx = 8;
    int m_d1 = 1, m_d2 = 1;

    always #10 clk = ~clk;  // 50 MHz

    microstep_translator u_microstep_translator (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .vdd_low(vdd_low),
        .step_in(step_in), .dir_in(dir_in), .res_sel(res_sel),
        .decay_sel(decay_sel), .ph1_set(ph1_set), .ph2_set(ph2_set),
        .ph1_decay(ph1_decay), .ph2_decay(ph2_decay), .at_home(at_home)
    );

    function automatic int ref_sin(int i);
        real a;
        a = 2.0 * 3.14159265358979 * real'(i) / 64.0;
        return int'(127.0 * $sin(a));
    endfunction

    function automatic int ref_abs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int ref_inc(logic [1:0] r);
        case (r)
            2'b00: return 16;
            2'b01: return 8;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_ext(logic [1:0] d);
        return (d == 2'b00) ? 0 : (d == 2'b10) ? 2 : 1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk(req, "ph1_set", int'(ph1_set), ref_sin((m_idx + 16) % 64));
        chk(req, "ph2_set", int'(ph2_set), ref_sin(m_idx));
        chk(req, "at_home (R9)", int'(at_home), (m_idx == 8) ? 1 : 0);
        chk(req, "ph1_decay", int'(ph1_decay), m_d1);
        chk(req, "ph2_decay", int'(ph2_decay), m_d2);
    endtask

    // Reference model of one accepted step.
    task automatic model_step();
        int n, o1, o2, n1, n2;
        n  = (m_idx + (dir_in ? ref_inc(res_sel) : 64 - ref_inc(res_sel))) % 64;
        o1 = ref_abs(ref_sin((m_idx + 16) % 64)); o2 = ref_abs(ref_sin(m_idx));
        n1 = ref_abs(ref_sin((n + 16) % 64));     n2 = ref_abs(ref_sin(n));
        m_d1 = (n1 < o1) ? ref_ext(decay_sel) : 0;
        m_d2 = (n2 < o2) ? ref_ext(decay_sel) : 0;
        m_idx = n;
    endtask

    task automatic pulse_step(bit accepted);
        step_in = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        step_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (accepted) model_step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_idx = 8; m_d1 = 1; m_d2 = 1;
        check_state("R5/R8 reset");
    endtask

    task automatic t_sixteenth_cycle();
        res_sel = 2'b11; dir_in = 1'b1; decay_sel = 2'b10;
        for (int i = 0; i < 64; i++) begin
            pulse_step(1);
            check_state("R1/R6/R7 sixteenth up");
        end
    endtask

    task automatic t_latency();
        int p1;
        res_sel = 2'b11; dir_in = 1'b1;
        p1 = int'(ph2_set);
        step_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 latency", "ph2 before 3rd edge", int'(ph2_set), p1);
        @(posedge clk);
        @(negedge clk);
        model_step();
        check_state("R2 after 3rd edge");
        repeat (20) @(posedge clk);
        @(negedge clk);
        check_state("R2 held high no move");
        step_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_full_reverse_wrap();
        res_sel = 2'b00; dir_in = 1'b0; decay_sel = 2'b01;
        for (int i = 0; i < 6; i++) begin
            pulse_step(1);
            check_state("R4/R1 full reverse wrap");
        end
    endtask

    task automatic t_half_eighth();
        res_sel = 2'b01; dir_in = 1'b1; decay_sel = 2'b11;
        for (int i = 0; i < 9; i++) begin
            pulse_step(1);
            check_state("R1/R7 half up");
        end
        res_sel = 2'b10; dir_in = 1'b0; decay_sel = 2'b00;
        for (int i = 0; i < 33; i++) begin
            pulse_step(1);
            check_state("R1/R7 eighth down");
        end
    endtask

    task automatic t_sampled_only();
        res_sel = 2'b11; dir_in = 1'b1;
        pulse_step(1);
        res_sel = 2'b00; dir_in = 1'b0; decay_sel = 2'b10;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check_state("R3 no effect without step");
        pulse_step(1);
        check_state("R3 applied at step");
    endtask

    task automatic t_hold(bit use_sleep);
        res_sel = 2'b01; dir_in = 1'b1;
        pulse_step(1);
        if (use_sleep) sleep_n = 1'b0; else vdd_low = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_idx = 8; m_d1 = 1; m_d2 = 1;
        check_state(use_sleep ? "R5/R8 sleep home" : "R5/R8 vdd_low home");
        pulse_step(0);
        check_state("R5 step ignored while held");
        sleep_n = 1'b1; vdd_low = 1'b0;
        pulse_step(1);
        check_state("R5 step from home after release");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_sixteenth_cycle();
        t_latency();
        t_full_reverse_wrap();
        t_half_eighth();
        t_sampled_only();
        t_hold(1'b1);
        t_hold(1'b0);
        pulse_step(1);
        t_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule